// File: doc/BRIEF.md
# Zero-Overhead Loop Instruction Cache

This block is a small instruction buffer that sits between instruction fetch and decode and runs the innermost loop of a program without fetch overhead. A loop-start command carries a body length and an iteration count. On the first pass the block asks memory for instructions, hands each accepted instruction on to decode, and writes a copy into its buffer. Every later pass is played from the buffer, back to back, with no fetch and no branch bubble between passes. A fetch that is held off during the first pass, for example because the fetch port loses arbitration to a data access, only delays that pass. It does not disturb the order of the instructions.

A re-run command plays the body that is already in the buffer again for a new iteration count and does not touch memory. Only one loop level exists. A command that arrives while a loop is running is dropped and raises a nesting error. A command whose length or count is out of range is refused with a range error.

Top module: `zloop_cache`

## Requirements
- R1: An accepted loop-start raises `mem_req`. Each instruction taken while `fetch_valid` is high appears on `out_instr` with `out_valid` high in the next cycle, in fetch order.
- R2: After the first pass, `out_valid` stays high in every cycle until length × count instructions have been delivered, and the body repeats in order.
- R3: The body length must be 1 to DEPTH (31 by default) and the count 1 to 2^CNT_W−1 (65535 by default). A length of 0, a length above DEPTH, or a count of 0 gives a one-cycle `err_range` pulse in the next cycle, and no loop starts.
- R4: A cycle in the first pass with `fetch_valid` low gives a cycle without output and does not change the order or the content of the instructions.
- R5: `mem_req` is high only while the first pass waits for instructions. It falls once the last body instruction has been taken. `fetch_valid` has no effect at any other time.
- R6: A re-run plays the cached body for `cmd_count` passes and never raises `mem_req`. A re-run with count 0, or with no complete body in the buffer, gives `err_range`.
- R7: A start or re-run command while `busy` is high is ignored and gives a one-cycle `err_nest` pulse in the next cycle. The running loop continues unchanged.
- R8: `done` is high for exactly one cycle: the cycle in which the final instruction of the last pass is on the output. `busy` is low in that cycle.
- R9: When start and re-run arrive in the same cycle, start wins.
- R10: After reset, `busy`, `done`, `mem_req`, `out_valid`, `err_range` and `err_nest` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_valid | input | 1 | Fetch-side instruction is present |
| fetch_instr | input | DATA_W | Instruction from memory |
| cmd_start | input | 1 | Loop-start command |
| cmd_rerun | input | 1 | Re-run the cached body |
| cmd_len | input | LEN_W | Body length for loop-start |
| cmd_count | input | CNT_W | Iteration count for start or re-run |
| out_valid | output | 1 | Instruction on `out_instr` is valid |
| out_instr | output | DATA_W | Instruction towards decode |
| mem_req | output | 1 | Buffer needs instructions from memory |
| busy | output | 1 | A loop is filling or replaying |
| done | output | 1 | Final instruction of the loop is on the output |
| err_range | output | 1 | Command refused: length or count out of range, or nothing cached |
| err_nest | output | 1 | Command refused: a loop is already running |

## Verification
The bench builds the block with the default 31-entry buffer and 32-bit instructions, so a body that fills every entry and a length one past the end can both be tried. It narrows the count to 8 bits, which puts the largest legal count (255) within a few thousand cycles. A 31-instruction loop is run at that count with periodic fetch stalls, so both ends of the length range and the top of the count range are covered in one run.

// File: rtl/zloop_pkg.sv
package zloop_pkg;
   typedef enum logic [1:0] {
      ZL_IDLE   = 2'd0,
      ZL_FILL   = 2'd1,
      ZL_REPLAY = 2'd2,
      ZL_DONE   = 2'd3
   } zl_state_e;
endpackage

// File: rtl/zloop_store.sv
module zloop_store #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 31,
   parameter int IDX_W  = 5
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] ent [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
         if (wr_en && (wr_idx == IDX_W'(g))) q <= wr_data;
      end
      assign ent[g] = q;
   end

   always_comb begin
      rd_data = '0;
      if (int'(rd_idx) < DEPTH) rd_data = ent[rd_idx];
   end
endmodule

// File: rtl/zloop_ctrl.sv
module zloop_ctrl
   import zloop_pkg::*;
#(
   parameter int DEPTH = 31,
   parameter int CNT_W = 16,
   parameter int LEN_W = 6,
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_start,
   input  logic             cmd_rerun,
   input  logic [LEN_W-1:0] cmd_len,
   input  logic [CNT_W-1:0] cmd_count,
   input  logic             fetch_valid,
   output zl_state_e        state,
   output logic [IDX_W-1:0] idx,
   output logic             wr_en,
   output logic             err_range,
   output logic             err_nest
);
   zl_state_e        st_q, st_d;
   logic [IDX_W-1:0] idx_q, idx_d;
   logic [LEN_W-1:0] len_q, len_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             cached_q, cached_d;

   logic idle_like, len_ok, cnt_ok;
   logic take_start, bad_start, take_rerun, bad_rerun, nest_hit;
   logic beat, at_end;

   assign idle_like  = (st_q == ZL_IDLE) || (st_q == ZL_DONE);
   assign len_ok     = (cmd_len != '0) && (int'(cmd_len) <= DEPTH);
   assign cnt_ok     = (cmd_count != '0);
   assign take_start = idle_like && cmd_start && len_ok && cnt_ok;
   assign bad_start  = idle_like && cmd_start && !(len_ok && cnt_ok);
   assign take_rerun = idle_like && !cmd_start && cmd_rerun && cached_q && cnt_ok;
   assign bad_rerun  = idle_like && !cmd_start && cmd_rerun && !(cached_q && cnt_ok);
   assign nest_hit   = !idle_like && (cmd_start || cmd_rerun);

   assign beat   = ((st_q == ZL_FILL) && fetch_valid) || (st_q == ZL_REPLAY);
   assign at_end = beat && (LEN_W'(idx_q) == (len_q - LEN_W'(1)));

   always_comb begin
      st_d     = st_q;
      idx_d    = idx_q;
      len_d    = len_q;
      cnt_d    = cnt_q;
      cached_d = cached_q;
      unique case (st_q)
         ZL_IDLE, ZL_DONE: begin
            st_d = ZL_IDLE;
            if (take_start) begin
               st_d     = ZL_FILL;
               len_d    = cmd_len;
               cnt_d    = cmd_count;
               idx_d    = '0;
               cached_d = 1'b0;
            end else if (take_rerun) begin
               st_d  = ZL_REPLAY;
               cnt_d = cmd_count;
               idx_d = '0;
            end
         end
         ZL_FILL, ZL_REPLAY: begin
            if (beat) begin
               if (at_end) begin
                  idx_d    = '0;
                  cached_d = 1'b1;
                  if (cnt_q == CNT_W'(1)) begin
                     st_d = ZL_DONE;
                  end else begin
                     st_d  = ZL_REPLAY;
                     cnt_d = cnt_q - CNT_W'(1);
                  end
               end else begin
                  idx_d = idx_q + IDX_W'(1);
               end
            end
         end
         default: st_d = ZL_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ZL_IDLE;
         idx_q     <= '0;
         len_q     <= '0;
         cnt_q     <= '0;
         cached_q  <= 1'b0;
         err_range <= 1'b0;
         err_nest  <= 1'b0;
      end else begin
         st_q      <= st_d;
         idx_q     <= idx_d;
         len_q     <= len_d;
         cnt_q     <= cnt_d;
         cached_q  <= cached_d;
         err_range <= bad_start || bad_rerun;
         err_nest  <= nest_hit;
      end
   end

   assign state = st_q;
   assign idx   = idx_q;
   assign wr_en = (st_q == ZL_FILL) && fetch_valid;
endmodule

// File: rtl/zloop_outstage.sv
module zloop_outstage
   import zloop_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter bit HOLD_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  zl_state_e         state,
   input  logic              fetch_valid,
   input  logic [DATA_W-1:0] fetch_instr,
   input  logic [DATA_W-1:0] rd_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_instr
);
   logic              pass_fetch, pass_buf, nxt_valid;
   logic [DATA_W-1:0] nxt_data;

   assign pass_fetch = (state == ZL_FILL) && fetch_valid;
   assign pass_buf   = (state == ZL_REPLAY);
   assign nxt_valid  = pass_fetch || pass_buf;
   assign nxt_data   = pass_fetch ? fetch_instr : rd_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= nxt_valid;
   end

   if (HOLD_DATA) begin : g_hold
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         out_instr <= '0;
         else if (nxt_valid) out_instr <= nxt_data;
      end
   end else begin : g_clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) out_instr <= '0;
         else        out_instr <= nxt_valid ? nxt_data : '0;
      end
   end
endmodule

// File: rtl/zloop_cache.sv
module zloop_cache
   import zloop_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int DEPTH     = 31,
   parameter int CNT_W     = 16,
   parameter bit HOLD_DATA = 1'b1,
   localparam int LEN_W    = $clog2(DEPTH + 2),
   localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_valid,
   input  logic [DATA_W-1:0] fetch_instr,
   input  logic              cmd_start,
   input  logic              cmd_rerun,
   input  logic [LEN_W-1:0]  cmd_len,
   input  logic [CNT_W-1:0]  cmd_count,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_instr,
   output logic              mem_req,
   output logic              busy,
   output logic              done,
   output logic              err_range,
   output logic              err_nest
);
   initial begin : p_param_chk
      assert (DATA_W >= 1) else $error("zloop_cache: DATA_W must be at least 1");
      assert (DEPTH >= 1 && DEPTH <= 256) else $error("zloop_cache: DEPTH must be 1..256");
      assert (CNT_W >= 1 && CNT_W <= 32) else $error("zloop_cache: CNT_W must be 1..32");
   end

   zl_state_e         state;
   logic [IDX_W-1:0]  idx;
   logic              wr_en;
   logic [DATA_W-1:0] rd_data;

   zloop_ctrl #(
      .DEPTH (DEPTH),
      .CNT_W (CNT_W),
      .LEN_W (LEN_W),
      .IDX_W (IDX_W)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_start   (cmd_start),
      .cmd_rerun   (cmd_rerun),
      .cmd_len     (cmd_len),
      .cmd_count   (cmd_count),
      .fetch_valid (fetch_valid),
      .state       (state),
      .idx         (idx),
      .wr_en       (wr_en),
      .err_range   (err_range),
      .err_nest    (err_nest)
   );

   zloop_store #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH),
      .IDX_W  (IDX_W)
   ) u_store (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_idx  (idx),
      .wr_data (fetch_instr),
      .rd_idx  (idx),
      .rd_data (rd_data)
   );

   zloop_outstage #(
      .DATA_W    (DATA_W),
      .HOLD_DATA (HOLD_DATA)
   ) u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .state       (state),
      .fetch_valid (fetch_valid),
      .fetch_instr (fetch_instr),
      .rd_data     (rd_data),
      .out_valid   (out_valid),
      .out_instr   (out_instr)
   );

   assign mem_req = (state == ZL_FILL);
   assign busy    = (state == ZL_FILL) || (state == ZL_REPLAY);
   assign done    = (state == ZL_DONE);
endmodule

// File: rtl/zloop_cache_chk.sv
module zloop_cache_chk (
   input logic clk,
   input logic rst_n,
   input logic cmd_start,
   input logic cmd_rerun,
   input logic out_valid,
   input logic mem_req,
   input logic busy,
   input logic done,
   input logic err_range,
   input logic err_nest
);
   // R8: done lasts exactly one cycle
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8: done only ends a loop that was running
   a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(busy));

   // R5: memory is requested only inside an active loop
   a_r5_memreq_busy: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);

   // R2: replay delivers an instruction every cycle
   a_r2_replay_continuous: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !mem_req) |=> out_valid);

   // R7: a command during a loop is flagged
   a_r7_nest_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (cmd_start || cmd_rerun)) |=> err_nest);

   // R3: a refused command leaves the block idle
   a_r3_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
      err_range |-> !busy);

   // R7: the two error flags never fire together
   a_r7_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(err_range && err_nest));
endmodule

bind zloop_cache zloop_cache_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_start (cmd_start),
   .cmd_rerun (cmd_rerun),
   .out_valid (out_valid),
   .mem_req   (mem_req),
   .busy      (busy),
   .done      (done),
   .err_range (err_range),
   .err_nest  (err_nest)
);

// File: tb/zloop_cache_tb_top.sv
`timescale 1ns/1ps
module zloop_cache_tb_top;
   localparam int DATA_W = 32;
   localparam int DEPTH  = 31;
   localparam int CNT_W  = 8;
   localparam int LEN_W  = $clog2(DEPTH + 2);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              fetch_valid = 1'b0;
   logic [DATA_W-1:0] fetch_instr = '0;
   logic              cmd_start = 1'b0;
   logic              cmd_rerun = 1'b0;
   logic [LEN_W-1:0]  cmd_len = '0;
   logic [CNT_W-1:0]  cmd_count = '0;
   logic              out_valid, mem_req, busy, done, err_range, err_nest;
   logic [DATA_W-1:0] out_instr;

   int n_vec = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   zloop_cache #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH),
      .CNT_W  (CNT_W)
   ) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .fetch_valid (fetch_valid),
      .fetch_instr (fetch_instr),
      .cmd_start   (cmd_start),
      .cmd_rerun   (cmd_rerun),
      .cmd_len     (cmd_len),
      .cmd_count   (cmd_count),
      .out_valid   (out_valid),
      .out_instr   (out_instr),
      .mem_req     (mem_req),
      .busy        (busy),
      .done        (done),
      .err_range   (err_range),
      .err_nest    (err_nest)
   );

   function automatic logic [DATA_W-1:0] body_word(int seed, int i);
      return 32'hA500_0000 ^ (DATA_W'(seed) << 12) ^ DATA_W'(i * 7 + 1);
   endfunction

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !mem_req && !out_valid && !err_range && !err_nest,
          "R10", "outputs idle after reset",
          {busy, done, mem_req, out_valid, err_range, err_nest}, 0);
   endtask

   // one refused command: err_range pulses, no loop starts
   task automatic t_refuse(string req, bit st, bit rr, int len, int cnt);
      cmd_start = st; cmd_rerun = rr;
      cmd_len = LEN_W'(len); cmd_count = CNT_W'(cnt);
      @(negedge clk);
      cmd_start = 1'b0; cmd_rerun = 1'b0;
      chk(err_range && !err_nest, req, "err_range after refused command", {err_range, err_nest}, 2);
      chk(!busy && !mem_req, req, "no loop after refused command", {busy, mem_req}, 0);
      @(negedge clk);
      chk(!err_range, req, "err_range is a single pulse", err_range, 0);
   endtask

   // start or re-run a loop and follow it to the end
   task automatic t_loop(string req, int len, int cnt, bit stall, bit rerun,
                         bit poke, bit both, int seed);
      int  fed = 0, got = 0, gaps = 0, dones = 0, cyc = 0, wrong = 0, xreq = 0;
      int  total = len * cnt;
      bit  nest_seen = 1'b0;
      bit  req_seen  = 1'b0;
      cmd_count = CNT_W'(cnt);
      cmd_len   = LEN_W'(len);
      if (rerun) cmd_rerun = 1'b1;
      else begin cmd_start = 1'b1; cmd_rerun = both; end
      @(negedge clk);
      cmd_start = 1'b0; cmd_rerun = 1'b0;
      chk(busy, req, "busy after accepted command", busy, 1);
      while (dones == 0 && cyc < total * 3 + 20) begin
         if (out_valid) begin
            if (out_instr !== body_word(seed, got % len)) wrong++;
            got++;
         end else if (got >= len && got < total) gaps++;
         if (mem_req) req_seen = 1'b1;
         if (mem_req && (rerun || fed == len)) xreq++;
         if (err_nest) nest_seen = 1'b1;
         if (done) begin
            dones++;
            chk(out_valid && got == total && !busy, "R8",
                "done with final instruction, busy low", got, total);
         end
         fetch_valid = 1'b0;
         fetch_instr = 32'h0BAD_0000 | DATA_W'(cyc);
         if (rerun || fed == len) begin
            fetch_valid = 1'b1;
         end else if (mem_req && fed < len) begin
            if (!(stall && (cyc % 3 == 1))) begin
               fetch_valid = 1'b1;
               fetch_instr = body_word(seed, fed);
               fed++;
            end
         end
         cmd_start = poke && (cyc == len + 2);
         cmd_len   = LEN_W'(1);
         cyc++;
         @(negedge clk);
      end
      fetch_valid = 1'b0;
      cmd_start   = 1'b0;
      chk(wrong == 0, rerun ? "R6" : (stall ? "R4" : "R1"), "instruction mismatches", wrong, 0);
      chk(got == total, "R2", "instructions delivered", got, total);
      chk(gaps == 0, "R2", "gaps after first pass", gaps, 0);
      chk(dones == 1, "R8", "done pulses", dones, 1);
      chk(xreq == 0, rerun ? "R6" : "R5", "stray memory requests", xreq, 0);
      if (!rerun) chk(req_seen, both ? "R9" : "R1", "memory requested during fill", req_seen, 1);
      if (poke) chk(nest_seen, "R7", "nesting error raised", nest_seen, 1);
      chk(!done && !busy, "R8", "done gone and idle one cycle later", {done, busy}, 0);
   endtask

   initial begin : p_watchdog
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin : p_main
      t_reset();
      t_refuse("R6", 1'b0, 1'b1, 0, 5);            // R6: nothing cached yet
      t_refuse("R3", 1'b1, 1'b0, 0, 3);            // R3: length 0
      t_refuse("R3", 1'b1, 1'b0, DEPTH + 1, 3);    // R3: length above DEPTH
      t_refuse("R3", 1'b1, 1'b0, 4, 0);            // R3: count 0
      t_loop("R1", 4, 3, 1'b0, 1'b0, 1'b0, 1'b0, 1);
      t_loop("R4", 5, 4, 1'b1, 1'b0, 1'b0, 1'b0, 2);
      t_loop("R6", 5, 6, 1'b0, 1'b1, 1'b0, 1'b0, 2);
      t_refuse("R6", 1'b0, 1'b1, 0, 0);            // R6: re-run count 0
      t_loop("R3", DEPTH, 255, 1'b1, 1'b0, 1'b0, 1'b0, 3);
      t_loop("R3", 1, 1, 1'b0, 1'b0, 1'b0, 1'b0, 4);
      t_loop("R7", 3, 5, 1'b0, 1'b0, 1'b1, 1'b0, 5);
      t_loop("R9", 2, 2, 1'b0, 1'b0, 1'b0, 1'b1, 6);
      t_loop("R2", 1, 4, 1'b0, 1'b0, 1'b0, 1'b0, 7);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule